// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked on-chip request bus and an external asynchronous static RAM of 64K words by 16 bits. A requester presents one word access at a time through a valid/ready handshake, with a 16-bit word address, 16-bit write data, a write flag and a two-bit lane mask. The controller turns each access into the chip-select, write-strobe, output-enable and byte-lane strobe sequence that the memory expects. Read data returns on a response port with a one-cycle valid pulse.

Each phase of an access lasts a number of clock cycles set by a parameter, so the memory's nanosecond limits can be met at any clock rate. The memory-side data bus is split into a driven value, a drive enable and a sampled input, which a pad ring joins into one bidirectional bus. The memory is in standby whenever no access is in flight. After every access there is an idle gap on the bus, so the controller never drives data while the memory may still be driving its outputs.

States: `ST_IDLE` (ready, standby), `ST_READ`, `ST_WSETUP`, `ST_WPULSE`, `ST_WHOLD`, `ST_TURN`. Transitions: IDLE to READ or WSETUP on an accepted request. READ to TURN after `RD_CYCLES`, with data captured. WSETUP to WPULSE after `WR_SETUP_CYCLES`. WPULSE to WHOLD after `WR_PULSE_CYCLES`. WHOLD to TURN after one cycle. TURN to IDLE after `TURN_CYCLES`.

Top module: `sram_bus_ctrl`

## Requirements
- R1: A synchronous reset (rst_n low) sets mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n and mem_ub_n high, mem_dq_oe low, rsp_valid low. After reset, req_ready is high.
- R2: A request is taken only on a clock edge where req_valid and req_ready are both high. req_ready is low from that edge until the access and its turnaround are complete. Address, write data, lane mask and write flag are captured at that edge, and later changes on the request inputs do not affect the access.
- R3: While req_ready is high, mem_ce_n is high, so the memory sits in standby.
- R4: A read (req_we=0) holds mem_ce_n=0, mem_oe_n=0, mem_we_n=1 and mem_dq_oe=0 for exactly RD_CYCLES cycles. mem_dq_i is sampled at the last of those edges, and rsp_valid is high for exactly one cycle, in the first cycle after the read phase.
- R5: Lane mask bit 0 enables data bits 7:0 through mem_lb_n low, and bit 1 enables bits 15:8 through mem_ub_n low. A lane disabled on a read returns 8'h00 in rsp_rdata.
- R6: A write (req_we=1) first drives address and data with mem_ce_n=0 and mem_we_n=1 for WR_SETUP_CYCLES cycles. It then holds mem_we_n=0 for WR_PULSE_CYCLES cycles, then returns mem_we_n=1 for one cycle with the data still driven. mem_oe_n stays high through the whole write.
- R7: mem_addr and mem_dq_o do not change while mem_we_n stays low.
- R8: A lane disabled on a write leaves that byte of the memory word unchanged.
- R9: After every access, all memory strobes are high and mem_dq_oe is low for TURN_CYCLES cycles before req_ready returns high.
- R10: mem_dq_oe is never high while mem_oe_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane enables, bit0 = bits 7:0, bit1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 16 | Memory address |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_lb_n | output | 1 | Lower lane strobe, active low |
| mem_ub_n | output | 1 | Upper lane strobe, active low |
| mem_dq_o | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 16 | Data sampled from the memory bus |

## Verification
The hardest condition to reach is a mismatch between what the controller drives and what the memory actually stores. A byte written through only one lane, or a write strobe released a cycle too early, looks correct at the pins unless the stored word is read back later. The bench therefore pairs a behavioural memory, which stores data only on the rising write strobe and honours the lane strobes, with a shadow copy kept from the requirements. Partial-lane writes over known words are followed by full and partial reads, and the scoreboard compares those reads. The bench runs with non-default phase lengths, so that every counter boundary is crossed, and it changes the request inputs right after acceptance.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READ   = 3'd1,
        ST_WSETUP = 3'd2,
        ST_WPULSE = 3'd3,
        ST_WHOLD  = 3'd4,
        ST_TURN   = 3'd5
    } sram_state_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic drive;
        logic lanes_on;
    } pin_ctrl_t;

    function automatic pin_ctrl_t pins_for(sram_state_e st);
        pin_ctrl_t p;
        p = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0, lanes_on: 1'b0};
        unique case (st)
            ST_READ:   p = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, drive: 1'b0, lanes_on: 1'b1};
            ST_WSETUP: p = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drive: 1'b1, lanes_on: 1'b1};
            ST_WPULSE: p = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, drive: 1'b1, lanes_on: 1'b1};
            ST_WHOLD:  p = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drive: 1'b1, lanes_on: 1'b1};
            ST_IDLE, ST_TURN: p = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0, lanes_on: 1'b0};
            default:   p = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0, lanes_on: 1'b0};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_req_latch.sv
module sram_req_latch #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          capture,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW/8-1:0] req_mask,
    input  logic [DW-1:0] mem_dq_i,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW/8-1:0] lane_en,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata
);
    localparam int LANES = DW / 8;

    logic [LANES-1:0] mask_q;
    logic [DW-1:0]    lane_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            mask_q  <= req_mask;
        end
    end

    assign lane_en = accept ? req_mask : mask_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_data[g*8 +: 8] = mask_q[g] ? mem_dq_i[g*8 +: 8] : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture)
                rsp_rdata <= lane_data;
        end
    end
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int RD_CYCLES       = 2,
    parameter int WR_SETUP_CYCLES = 1,
    parameter int WR_PULSE_CYCLES = 1,
    parameter int TURN_CYCLES     = 1,
    parameter int CW              = 2,
    parameter int LANES           = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_we,
    input  logic [LANES-1:0] lane_en,
    input  logic             tmr_done,
    output logic             tmr_load,
    output logic [CW-1:0]    tmr_val,
    output logic             accept,
    output logic             capture,
    output logic             req_ready,
    output logic             mem_ce_n,
    output logic             mem_we_n,
    output logic             mem_oe_n,
    output logic [LANES-1:0] mem_lane_n,
    output logic             mem_dq_oe
);
    localparam logic [CW-1:0] LD_RD = CW'(RD_CYCLES - 1);
    localparam logic [CW-1:0] LD_WS = CW'(WR_SETUP_CYCLES - 1);
    localparam logic [CW-1:0] LD_WP = CW'(WR_PULSE_CYCLES - 1);
    localparam logic [CW-1:0] LD_TC = CW'(TURN_CYCLES - 1);

    sram_state_e state_q, state_d;
    pin_ctrl_t   pins_d;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // transitions and phase timer loads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    tmr_load = 1'b1;
                    if (req_we) begin
                        state_d = ST_WSETUP;
                        tmr_val = LD_WS;
                    end else begin
                        state_d = ST_READ;
                        tmr_val = LD_RD;
                    end
                end
            end
            ST_READ: begin
                if (tmr_done) begin
                    capture  = 1'b1;
                    state_d  = ST_TURN;
                    tmr_load = 1'b1;
                    tmr_val  = LD_TC;
                end
            end
            ST_WSETUP: begin
                if (tmr_done) begin
                    state_d  = ST_WPULSE;
                    tmr_load = 1'b1;
                    tmr_val  = LD_WP;
                end
            end
            ST_WPULSE: begin
                if (tmr_done) begin
                    state_d  = ST_WHOLD;
                    tmr_load = 1'b1;
                end
            end
            ST_WHOLD: begin
                state_d  = ST_TURN;
                tmr_load = 1'b1;
                tmr_val  = LD_TC;
            end
            ST_TURN: begin
                if (tmr_done)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign pins_d = pins_for(state_d);

    // registered pin outputs, decoded from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ce_n   <= 1'b1;
            mem_we_n   <= 1'b1;
            mem_oe_n   <= 1'b1;
            mem_dq_oe  <= 1'b0;
            mem_lane_n <= '1;
        end else begin
            mem_ce_n   <= pins_d.ce_n;
            mem_we_n   <= pins_d.we_n;
            mem_oe_n   <= pins_d.oe_n;
            mem_dq_oe  <= pins_d.drive;
            mem_lane_n <= ~({LANES{pins_d.lanes_on}} & lane_en);
        end
    end
endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl #(
    parameter int AW              = 16,
    parameter int DW              = 16,
    parameter int RD_CYCLES       = 2,
    parameter int WR_SETUP_CYCLES = 1,
    parameter int WR_PULSE_CYCLES = 1,
    parameter int TURN_CYCLES     = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [1:0]    req_mask,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic          mem_lb_n,
    output logic          mem_ub_n,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_i
);
    localparam int LANES = DW / 8;
    localparam int MAX_A = (RD_CYCLES > WR_SETUP_CYCLES) ? RD_CYCLES : WR_SETUP_CYCLES;
    localparam int MAX_B = (WR_PULSE_CYCLES > TURN_CYCLES) ? WR_PULSE_CYCLES : TURN_CYCLES;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW    = $clog2(MAX_C + 1);

    logic             tmr_load, tmr_done, accept, capture;
    logic [CW-1:0]    tmr_val;
    logic [LANES-1:0] lane_en, lane_n;

    sram_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_req_latch #(.AW(AW), .DW(DW)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_mask  (req_mask),
        .mem_dq_i  (mem_dq_i),
        .addr_q    (mem_addr),
        .wdata_q   (mem_dq_o),
        .lane_en   (lane_en),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    sram_ctrl_fsm #(
        .RD_CYCLES       (RD_CYCLES),
        .WR_SETUP_CYCLES (WR_SETUP_CYCLES),
        .WR_PULSE_CYCLES (WR_PULSE_CYCLES),
        .TURN_CYCLES     (TURN_CYCLES),
        .CW              (CW),
        .LANES           (LANES)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_we     (req_we),
        .lane_en    (lane_en),
        .tmr_done   (tmr_done),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .accept     (accept),
        .capture    (capture),
        .req_ready  (req_ready),
        .mem_ce_n   (mem_ce_n),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_lane_n (lane_n),
        .mem_dq_oe  (mem_dq_oe)
    );

    assign mem_lb_n = lane_n[0];
    assign mem_ub_n = lane_n[LANES-1];
endmodule

// File: rtl/sram_bus_ctrl_chk.sv
module sram_bus_ctrl_chk #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ce_n,
    input logic          mem_we_n,
    input logic          mem_oe_n,
    input logic [DW-1:0] mem_dq_o,
    input logic          mem_dq_oe
);
    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_idle_standby_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_ce_n);

    p_rsp_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_write_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

    p_addr_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_o)));

    p_turn_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce_n) |-> (!mem_dq_oe && mem_oe_n && mem_we_n));

    p_no_contention_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);
endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sram_bus_ctrl_test.sv
module sram_bus_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int RD  = 3;
    localparam int WS  = 2;
    localparam int WP  = 2;
    localparam int TC  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_we = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata, mem_addr, mem_dq_o, mem_dq_i;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;

    int checks = 0, errors = 0, contention = 0, moved = 0;
    logic [15:0] mem [256];
    logic [15:0] shadow [256];
    logic [15:0] exp_q [$];
    logic        prev_we_low = 1'b0;
    logic [15:0] prev_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_bus_ctrl #(
        .RD_CYCLES(RD), .WR_SETUP_CYCLES(WS), .WR_PULSE_CYCLES(WP), .TURN_CYCLES(TC)
    ) uut (.*);

    // behavioural memory: lanes drive only when enabled, stores on rising write strobe
    always_comb begin
        if (!mem_ce_n && !mem_oe_n && mem_we_n)
            mem_dq_i = {mem_ub_n ? 8'h5A : mem[mem_addr[7:0]][15:8],
                        mem_lb_n ? 8'h5A : mem[mem_addr[7:0]][7:0]};
        else
            mem_dq_i = 16'hC3C3;
    end

    always @(posedge mem_we_n) begin
        if (rst_n && !mem_ce_n) begin
            if (!mem_lb_n) mem[mem_addr[7:0]][7:0]  = mem_dq_o[7:0];
            if (!mem_ub_n) mem[mem_addr[7:0]][15:8] = mem_dq_o[15:8];
        end
    end

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // bus monitor for contention and frozen address
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_dq_oe && !mem_ce_n && !mem_oe_n && mem_we_n) contention++;
            if (!mem_we_n && prev_we_low && mem_addr != prev_addr) moved++;
            prev_we_low = !mem_we_n;
            prev_addr   = mem_addr;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected response", {16'h0, rsp_rdata}, 32'h0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check(rsp_rdata == e, "R4/R5/R8 read data", {16'h0, rsp_rdata}, {16'h0, e});
            end
        end
    end

    function automatic logic [1:0] lanes_n(input logic [1:0] m);
        return ~m;
    endfunction

    task automatic turn_and_ready();
        bit ok = 1;
        for (int i = 0; i < TC; i++) begin
            if (!(mem_ce_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe && !req_ready)) ok = 0;
            @(negedge clk);
        end
        check(ok, "R9 turnaround phase", {27'h0, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}, 32'h1C);
        check(req_ready && mem_ce_n, "R3 ready and standby", {30'h0, req_ready, mem_ce_n}, 32'h3);
    endtask

    task automatic do_write(input logic [15:0] a, input logic [15:0] d, input logic [1:0] m);
        bit ok;
        req_valid = 1; req_we = 1; req_addr = a; req_wdata = d; req_mask = m;
        @(negedge clk);
        req_valid = 0; req_addr = ~a; req_wdata = ~d; req_mask = ~m;
        check(!req_ready, "R2 busy after accept", {31'h0, req_ready}, 32'h0);
        ok = 1;
        for (int i = 0; i < WS; i++) begin
            if (!(!mem_ce_n && mem_we_n && mem_oe_n && mem_dq_oe && mem_dq_o == d && mem_addr == a
                  && {mem_ub_n, mem_lb_n} == lanes_n(m))) ok = 0;
            @(negedge clk);
        end
        check(ok, "R6/R2 write setup", {mem_addr, mem_dq_o}, {a, d});
        ok = 1;
        for (int i = 0; i < WP; i++) begin
            if (!(!mem_ce_n && !mem_we_n && mem_oe_n && mem_dq_oe && mem_dq_o == d && mem_addr == a)) ok = 0;
            @(negedge clk);
        end
        check(ok, "R6 write pulse", {31'h0, mem_we_n}, 32'h0);
        check(!mem_ce_n && mem_we_n && mem_dq_oe && mem_oe_n && mem_dq_o == d, "R6 write hold",
              {29'h0, mem_ce_n, mem_we_n, mem_dq_oe}, 32'h3);
        @(negedge clk);
        if (m[0]) shadow[a[7:0]][7:0]  = d[7:0];
        if (m[1]) shadow[a[7:0]][15:8] = d[15:8];
        turn_and_ready();
    endtask

    task automatic do_read(input logic [15:0] a, input logic [1:0] m);
        bit ok;
        exp_q.push_back({m[1] ? shadow[a[7:0]][15:8] : 8'h00, m[0] ? shadow[a[7:0]][7:0] : 8'h00});
        req_valid = 1; req_we = 0; req_addr = a; req_wdata = 16'hFFFF; req_mask = m;
        @(negedge clk);
        req_valid = 0; req_addr = ~a; req_mask = ~m; req_we = 1;
        ok = 1;
        for (int i = 0; i < RD; i++) begin
            if (!(!mem_ce_n && !mem_oe_n && mem_we_n && !mem_dq_oe && mem_addr == a && !rsp_valid
                  && {mem_ub_n, mem_lb_n} == lanes_n(m))) ok = 0;
            @(negedge clk);
        end
        check(ok, "R4/R5 read phase", {mem_addr, 14'h0, mem_ub_n, mem_lb_n}, {a, 14'h0, lanes_n(m)});
        check(rsp_valid, "R4 response strobe timing", {31'h0, rsp_valid}, 32'h1);
        turn_and_ready();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = '0;
            shadow[i] = '0;
        end
        repeat (3) @(negedge clk);
        check(mem_ce_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe && !rsp_valid,
              "R1 reset outputs", {25'h0, mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe, rsp_valid}, 32'h7C);
        rst_n = 1;
        @(negedge clk);
        check(req_ready && mem_ce_n, "R1 ready after reset", {30'h0, req_ready, mem_ce_n}, 32'h3);

        do_write(16'h0011, 16'hA1B2, 2'b11);
        do_read (16'h0011, 2'b11);
        do_write(16'h0022, 16'h1234, 2'b11);
        do_write(16'h0022, 16'hFFEE, 2'b01);   // R8 upper lane kept
        do_read (16'h0022, 2'b11);
        do_write(16'h0022, 16'h77CC, 2'b10);   // R8 lower lane kept
        do_read (16'h0022, 2'b11);
        do_write(16'h0033, 16'h5566, 2'b11);
        do_write(16'h0033, 16'h0000, 2'b00);   // R8 no lane written
        do_read (16'h0033, 2'b11);
        do_read (16'h0033, 2'b10);             // R5 lower lane zero
        do_read (16'h0011, 2'b01);             // R5 upper lane zero
        do_read (16'h0044, 2'b00);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R4 all responses returned", exp_q.size(), 32'h0);
        check(contention == 0, "R10 no bus contention", contention, 32'h0);
        check(moved == 0, "R7 address frozen during write strobe", moved, 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule